// File: doc/BRIEF.md
# Word Copy DMA Engine

A single-channel engine that copies 16-bit words from one memory area to another without processor involvement. Software loads a source address, a destination address and a word count through a small register port. Loading a non-zero count starts the copy as a side effect. Each word is moved as one read on the memory bus followed by one write of the same data. Every bus access waits for the memory to signal ready.

The source address may point anywhere in a 22-bit word address space. It is held as a 16-bit low half and a 6-bit high half. The destination holds only 14 bits, so writes can reach only the low window where internal RAM and IO registers sit. Software tracks progress by reading the count register, which reports the words still to be copied. The copy is finished when that register reads zero.

Top module: `wdma_engine`

## Requirements
- R1: After reset, every register reads 0 and `mem_req` is low.
- R2: Register select 3 is the count register. Writing a non-zero value to it while the count is 0 starts a transfer, and a read request appears on the bus in the following cycle.
- R3: Each word is one read at the current source address, then one write of the data just read to the current destination address. The read and the write are never merged or reordered.
- R4: While `mem_req` is high and `mem_ready` is low, the request, address, write flag and write data stay unchanged. An access completes on a clock edge where both signals are high.
- R5: After each completed write, the source and destination addresses each advance by one and the count drops by one. Reading select 3 returns the words remaining. When it reaches 0, the bus goes quiet.
- R6: The destination register (select 2) holds 14 bits. On writes, `mem_addr` bits 21..14 are zero. Stepping past 0x3FFF wraps the destination to 0.
- R7: Writing 0 to the count register starts no bus activity, and the count stays 0.
- R8: While the count is non-zero, writes to the source, destination and count registers are ignored.
- R9: Select 0 holds source bits 15..0 and select 1 holds source bits 21..16 (data bits 5..0). Read addresses use all 22 bits, and a source increment carries from bit 15 into bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 src low, 1 src high, 2 dst, 3 count |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access, 0 for a read |
| mem_addr | output | 22 | Word address of the access |
| mem_wdata | output | 16 | Data for write accesses |
| mem_rdata | input | 16 | Data returned for read accesses |
| mem_ready | input | 1 | Memory completes the current access |

## Verification
The hardest condition to reach is a register write that lands in the middle of a transfer. It must be dropped, yet the transfer has to finish unchanged. The bench forces this case by slowing the modelled memory to several wait cycles per access, which keeps the busy window open long enough for a burst of register writes. The same slowed memory also holds each request stalled, so the request-hold rule gets exercised. Starting addresses are chosen so that the source carries across its 16-bit halves and the destination wraps at the top of its window within a single transfer.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } wdma_state_e;

  localparam logic [1:0] RSEL_SRC_LO = 2'd0;
  localparam logic [1:0] RSEL_SRC_HI = 2'd1;
  localparam logic [1:0] RSEL_DST    = 2'd2;
  localparam logic [1:0] RSEL_CNT    = 2'd3;

endpackage

// File: rtl/wdma_regs.sv
module wdma_regs
  import wdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SRC_W  = 22,
  parameter int DST_W  = 14,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              step,
  output logic [SRC_W-1:0]  src_q,
  output logic [DST_W-1:0]  dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              start,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int HI_W = SRC_W - DATA_W;

  logic              wr_idle;
  logic              src_en, dst_en, cnt_en;
  logic [SRC_W-1:0]  src_d;
  logic [DST_W-1:0]  dst_d;
  logic [CNT_W-1:0]  cnt_d;

  assign wr_idle = reg_wr & ~busy;
  assign start   = wr_idle && (reg_sel == RSEL_CNT) && (reg_wdata[CNT_W-1:0] != '0);

  always_comb begin
    src_en = 1'b0;
    src_d  = src_q;
    if (step) begin
      src_en = 1'b1;
      src_d  = src_q + SRC_W'(1);
    end else if (wr_idle && reg_sel == RSEL_SRC_LO) begin
      src_en = 1'b1;
      src_d  = {src_q[SRC_W-1:DATA_W], reg_wdata};
    end else if (wr_idle && reg_sel == RSEL_SRC_HI) begin
      src_en = 1'b1;
      src_d  = {reg_wdata[HI_W-1:0], src_q[DATA_W-1:0]};
    end
  end

  always_comb begin
    dst_en = 1'b0;
    dst_d  = dst_q;
    if (step) begin
      dst_en = 1'b1;
      dst_d  = dst_q + DST_W'(1);
    end else if (wr_idle && reg_sel == RSEL_DST) begin
      dst_en = 1'b1;
      dst_d  = reg_wdata[DST_W-1:0];
    end
  end

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (step) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
    end else if (wr_idle && reg_sel == RSEL_CNT) begin
      cnt_en = 1'b1;
      cnt_d  = reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
    end else if (src_en) begin
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst_q <= '0;
    end else if (dst_en) begin
      dst_q <= dst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    case (reg_sel)
      RSEL_SRC_LO: reg_rdata = src_q[DATA_W-1:0];
      RSEL_SRC_HI: reg_rdata = DATA_W'(src_q[SRC_W-1:DATA_W]);
      RSEL_DST:    reg_rdata = DATA_W'(dst_q);
      default:     reg_rdata = DATA_W'(cnt_q);
    endcase
  end

endmodule

// File: rtl/wdma_seq.sv
module wdma_seq
  import wdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic last,
  input  logic mem_ready,
  output logic busy,
  output logic rd_phase,
  output logic wr_phase,
  output logic capture,
  output logic step
);

  wdma_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  if (mem_ready) state_d = ST_WRITE;
      ST_WRITE: if (mem_ready) state_d = last ? ST_IDLE : ST_READ;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign rd_phase = (state_q == ST_READ);
  assign wr_phase = (state_q == ST_WRITE);
  assign busy     = rd_phase | wr_phase;
  assign capture  = rd_phase & mem_ready;
  assign step     = wr_phase & mem_ready;

endmodule

// File: rtl/wdma_bus.sv
module wdma_bus #(
  parameter int DATA_W = 16,
  parameter int SRC_W  = 22,
  parameter int DST_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_phase,
  input  logic              wr_phase,
  input  logic              capture,
  input  logic [SRC_W-1:0]  src_q,
  input  logic [DST_W-1:0]  dst_q,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [SRC_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic [SRC_W-1:0]  dst_ext;
  logic [DATA_W-1:0] word_q;

  generate
    if (SRC_W > DST_W) begin : g_pad
      assign dst_ext = {{(SRC_W-DST_W){1'b0}}, dst_q};
    end else begin : g_cut
      assign dst_ext = dst_q[SRC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (capture) begin
      word_q <= mem_rdata;
    end
  end

  assign mem_req   = rd_phase | wr_phase;
  assign mem_we    = wr_phase;
  assign mem_addr  = wr_phase ? dst_ext : src_q;
  assign mem_wdata = word_q;

endmodule

// File: rtl/wdma_engine.sv
module wdma_engine #(
  parameter int DATA_W     = 16,
  parameter int SRC_W      = 22,
  parameter int DST_W      = 14,
  parameter int CNT_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [SRC_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;
  logic [SRC_W-1:0]      src_q;
  logic [DST_W-1:0]      dst_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  start, last, busy;
  logic                  rd_phase, wr_phase, capture, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  assign last = (cnt_q == CNT_W'(1));

  wdma_regs #(
    .DATA_W(DATA_W), .SRC_W(SRC_W), .DST_W(DST_W), .CNT_W(CNT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .step(step), .src_q(src_q),
    .dst_q(dst_q), .cnt_q(cnt_q), .start(start), .reg_rdata(reg_rdata)
  );

  wdma_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .last(last),
    .mem_ready(mem_ready), .busy(busy), .rd_phase(rd_phase),
    .wr_phase(wr_phase), .capture(capture), .step(step)
  );

  wdma_bus #(
    .DATA_W(DATA_W), .SRC_W(SRC_W), .DST_W(DST_W)
  ) u_bus (
    .clk(clk), .rst_n(rst_sync_n), .rd_phase(rd_phase), .wr_phase(wr_phase),
    .capture(capture), .src_q(src_q), .dst_q(dst_q), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/wdma_engine_chk.sv
module wdma_engine_chk
  import wdma_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SRC_W  = 22,
  parameter int DST_W  = 14,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              mem_req,
  input logic              mem_we,
  input logic [SRC_W-1:0]  mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic [CNT_W-1:0]  cnt_q
);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we && mem_ready |=> mem_req && mem_we);

  // R6
  dst_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_addr >> DST_W) == '0);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 |-> !mem_req);

  // R8
  cnt_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0 && !(mem_req && mem_we && mem_ready) |=> $stable(cnt_q));

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 && reg_wr && reg_sel == RSEL_CNT && reg_wdata[CNT_W-1:0] != '0
      |=> mem_req && !mem_we);

endmodule

bind wdma_engine wdma_engine_chk #(
  .DATA_W(DATA_W), .SRC_W(SRC_W), .DST_W(DST_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .cnt_q(cnt_q)
);

// File: tb/wdma_engine_bench.sv
`timescale 1ns/1ps
module wdma_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'h0;
  logic        mem_ready = 1'b0;

  always #2 clk = ~clk;

  wdma_engine u_wdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  typedef struct {
    logic        we;
    logic [21:0] addr;
    logic [15:0] data;
  } item_t;

  item_t exp_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    lat = 0;
  int    wcnt = 0;
  logic  mon_on = 1'b0;
  logic  pend = 1'b0;
  logic  hold_we;
  logic [21:0] hold_addr;
  logic [15:0] hold_wdata;

  function automatic logic [15:0] mem_fn(input logic [21:0] a);
    logic [21:0] t;
    t = a * 22'd7 + 22'h01357;
    return t[15:0] ^ {10'h0, a[21:16]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [15:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  // Driver: pushes the expected read/write items, then programs the engine.
  task automatic start_xfer(input logic [21:0] src, input logic [13:0] dst,
                            input int n);
    logic [15:0] v;
    for (int i = 0; i < n; i++) begin
      item_t it;
      logic [21:0] s;
      logic [13:0] d;
      s = src + 22'(i);
      d = dst + 14'(i);
      it.we = 1'b0; it.addr = s; it.data = 16'h0;
      exp_q.push_back(it);
      it.we = 1'b1; it.addr = {8'h00, d}; it.data = mem_fn(s);
      exp_q.push_back(it);
    end
    reg_write(2'd0, src[15:0]);
    reg_write(2'd1, {10'h0, src[21:16]});
    reg_write(2'd2, {2'b00, dst});
    reg_write(2'd3, 16'(n));
    reg_read(2'd3, v);
    check("R5", "count right after start", 32'(v), 32'(n));
  endtask

  task automatic wait_done();
    logic [15:0] v;
    v = 16'hFFFF;
    for (int k = 0; k < 4000 && v != 16'h0; k++) begin
      @(negedge clk);
      reg_read(2'd3, v);
    end
    check("R5", "count reads zero at end", 32'(v), 32'h0);
    repeat (4) @(negedge clk);
    check("R5", "all expected words seen", 32'(exp_q.size()), 32'h0);
    check("R5", "bus quiet after end", 32'(mem_req), 32'h0);
  endtask

  // Monitor: memory responder plus scoreboard compare.
  always @(negedge clk) begin
    if (mon_on) begin
      if (pend) begin
        check("R4", "stalled request held",
              {9'h0, mem_req, mem_we, mem_addr[20:0]} ^ 32'(mem_wdata != hold_wdata),
              {9'h0, 1'b1, hold_we, hold_addr[20:0]});
        check("R4", "stalled address bit 21", 32'(mem_addr[21]), 32'(hold_addr[21]));
      end
      if (mem_req) begin
        if (wcnt >= lat) begin
          mem_ready = 1'b1; wcnt = 0;
        end else begin
          mem_ready = 1'b0; wcnt++;
        end
      end else begin
        mem_ready = 1'b0; wcnt = 0;
      end
      mem_rdata = mem_fn(mem_addr);
      if (mem_req && mem_ready) begin
        if (exp_q.size() == 0) begin
          check("R7", "unexpected bus access", {9'h0, mem_we, mem_addr}, 32'hFFFFFFFF);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          check("R3", "access kind", 32'(mem_we), 32'(it.we));
          check(it.we ? "R6" : "R9", "access address", 32'(mem_addr), 32'(it.addr));
          if (it.we) check("R3", "written data", 32'(mem_wdata), 32'(it.data));
        end
      end
      pend       = mem_req && !mem_ready;
      hold_we    = mem_we;
      hold_addr  = mem_addr;
      hold_wdata = mem_wdata;
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), v);
      check("R1", "register after reset", 32'(v), 32'h0);
    end
    check("R1", "mem_req after reset", 32'(mem_req), 32'h0);
    mon_on = 1'b1;

    // R2 R3 R5: plain copy, memory always ready
    lat = 0;
    start_xfer(22'h000010, 14'h0040, 5);
    wait_done();
    reg_read(2'd0, v); check("R5", "source after copy", 32'(v), 32'h0015);
    reg_read(2'd2, v); check("R5", "destination after copy", 32'(v), 32'h0045);

    // R4 R6 R9: stalls, source carry, destination wrap
    lat = 2;
    start_xfer(22'h2AFFFE, 14'h3FFE, 4);
    wait_done();
    reg_read(2'd0, v); check("R9", "source low after carry", 32'(v), 32'h0002);
    reg_read(2'd1, v); check("R9", "source high after carry", 32'(v), 32'h002B);
    reg_read(2'd2, v); check("R6", "destination wrapped", 32'(v), 32'h0002);

    // R7: zero count starts nothing
    reg_write(2'd3, 16'h0000);
    repeat (10) @(negedge clk);
    check("R7", "no request after zero count", 32'(mem_req), 32'h0);
    reg_read(2'd3, v); check("R7", "count stays zero", 32'(v), 32'h0);

    // R8: writes while busy are dropped
    lat = 3;
    start_xfer(22'h000100, 14'h0200, 4);
    reg_write(2'd0, 16'h1234);
    reg_write(2'd1, 16'h0011);
    reg_write(2'd2, 16'h0AAA);
    reg_write(2'd3, 16'h0009);
    wait_done();
    reg_read(2'd0, v); check("R8", "source low unaffected", 32'(v), 32'h0104);
    reg_read(2'd1, v); check("R8", "source high unaffected", 32'(v), 32'h0000);
    reg_read(2'd2, v); check("R8", "destination unaffected", 32'(v), 32'h0204);
    repeat (20) @(negedge clk);
    check("R8", "no extra words from busy count write", 32'(exp_q.size()), 32'h0);

    // R9 R5: single word from the top source segment
    lat = 1;
    start_xfer(22'h3F0007, 14'h1234, 1);
    wait_done();
    reg_read(2'd1, v); check("R9", "source high kept", 32'(v), 32'h003F);

    summary();
  end

endmodule